// File: doc/BRIEF.md
# Masked-Write Open-Drain GPIO Pair

This block is a single 32-bit control register that owns two open-drain pads, a clock line (line 0) and a data line (line 1). Software toggles the lines one register write at a time to produce I2C traffic; the block itself knows nothing of the protocol. Each line has a direction field, an output value field, two per-field write enables carried in the same write, a read-only synchronised input and a pull-up-disable bit.

A line is pulled low by driving it as an output with value 0. It goes high when it is switched back to input, which releases the pad to its pull-up; the block never needs to drive a 1. Because the direction and value fields only move when their own enable bit rides along in the same write, software can change one field without a read-modify-write of the others. A build-time option keeps the enables as stored state, so a write that omits them still updates the fields.

Top module: `gpio_pair_regs`

## Requirements
- R1: While reset is high and on the first cycles after it, both lines are inputs, both values are 0, all stored enables and pull-up-disable bits are 0, and `pad_oe` and `pad_out` are 0.
- R2: Line n uses write-data bits 8n+0 to 8n+5: +0 direction write enable, +1 direction (1 = drive, 0 = release), +2 value write enable, +3 value, +4 synchronised input (read-only), +5 pull-up disable. The direction field takes bit +1 of a write only when bit +0 of that same write is 1 (or the stored enable of R8 is set); otherwise it keeps its value.
- R3: The value field takes bit +3 of a write only when bit +2 of that same write is 1 (or the stored enable of R8 is set); otherwise it keeps its value.
- R4: Every write loads bit +5 of each line into that line's pull-up-disable bit, shown on `pad_pu_dis[n]`; with no write it holds.
- R5: `pad_oe[n]` equals the direction field and `pad_out[n]` the value field from the clock edge that accepts the write; one write with both enables, direction 1 and value 0 pulls the line low, and a write with only the direction enable and direction 0 releases it.
- R6: The read-only input bit of line n shows `pad_in[n]` through a two-stage synchroniser and the readback register: a change made between edges appears on `rd_data` after the third rising edge and not after the second.
- R7: With `LATCH_MASKS` = 0, read-back bits +0 and +2 of each line and bit 31 are always 0, and an enable given in one write has no effect on later writes.
- R8: With `LATCH_MASKS` = 1, a write with bit 31 set stores its bits +0 and +2 as the line's stored enables (old stored values still apply to that same write); a later write without enable bits then still updates the fields, and the stored enables read back on bits +0 and +2.
- R9: Direction, value and pull-up-disable bits read back on `rd_data` after the second rising edge from the write.
- R10: A write with no enable bits for one line leaves that line's direction and value unchanged whatever it does to the other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 32 | Write data in the layout of R2, bit 31 = enable store |
| rd_data | output | 32 | Registered readback of the register |
| pad_oe | output | 2 | Pad drive enable per line (0 = released) |
| pad_out | output | 2 | Pad drive value per line |
| pad_in | input | 2 | Sampled pad level per line, asynchronous |
| pad_pu_dis | output | 2 | Pull-up disable per line |

## Verification
A wrong enable or field bit shows at `pad_oe`/`pad_out` on the very edge after the offending write and on `rd_data` one edge later, so every combination of start state, enables and data is swept on each line and both pads and readback are compared after each write. A synchroniser that is one stage too short or too long shows as the input bit changing one edge early or late, which is probed at both the second and the third edge. Stored-enable state only shows through a later write that carries no enables, so the latched build is driven through load, use and clear sequences.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

  localparam int REG_W         = 32;
  localparam int LINE_STRIDE   = 8;
  localparam int FLD_DIR_WE    = 0;
  localparam int FLD_DIR       = 1;
  localparam int FLD_VAL_WE    = 2;
  localparam int FLD_VAL       = 3;
  localparam int FLD_IN        = 4;
  localparam int FLD_PU_DIS    = 5;
  localparam int MASK_LOAD_BIT = 31;

  typedef struct packed {
    logic pu_dis;
    logic val;
    logic val_we;
    logic dir;
    logic dir_we;
  } line_wr_t;

  function automatic line_wr_t unpack_line(input logic [REG_W-1:0] w, input int base);
    line_wr_t f;
    f.dir_we = w[base + FLD_DIR_WE];
    f.dir    = w[base + FLD_DIR];
    f.val_we = w[base + FLD_VAL_WE];
    f.val    = w[base + FLD_VAL];
    f.pu_dis = w[base + FLD_PU_DIS];
    return f;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= {STAGES{RESET_VAL}};
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];

endmodule

// File: rtl/gpio_line_ctl.sv
module gpio_line_ctl
  import gpio_pair_pkg::*;
#(
  parameter bit LATCH_MASKS = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  logic     mask_load,
  input  line_wr_t fields,
  output logic     dir_o,
  output logic     val_o,
  output logic     pu_dis_o,
  output logic     dir_we_o,
  output logic     val_we_o
);

  logic lat_dir_we;
  logic lat_val_we;
  logic dir_we_eff;
  logic val_we_eff;

  generate
    if (LATCH_MASKS) begin : g_latched
      always_ff @(posedge clk) begin
        if (rst) begin
          lat_dir_we <= 1'b0;
          lat_val_we <= 1'b0;
        end else if (wr_en && mask_load) begin
          lat_dir_we <= fields.dir_we;
          lat_val_we <= fields.val_we;
        end
      end
    end else begin : g_plain
      assign lat_dir_we = 1'b0;
      assign lat_val_we = 1'b0;
    end
  endgenerate

  // stored enables take effect together with the enables of the write itself
  assign dir_we_eff = fields.dir_we | lat_dir_we;
  assign val_we_eff = fields.val_we | lat_val_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_o    <= 1'b0;
      val_o    <= 1'b0;
      pu_dis_o <= 1'b0;
    end else if (wr_en) begin
      pu_dis_o <= fields.pu_dis;
      if (dir_we_eff) dir_o <= fields.dir;
      if (val_we_eff) val_o <= fields.val;
    end
  end

  assign dir_we_o = lat_dir_we;
  assign val_we_o = lat_val_we;

endmodule

// File: rtl/gpio_pair_regs.sv
module gpio_pair_regs
  import gpio_pair_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter bit LATCH_MASKS = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] pad_out,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_pu_dis
);

  localparam int USED_W = NUM_LINES * LINE_STRIDE;

  logic [NUM_LINES-1:0] dir_q;
  logic [NUM_LINES-1:0] val_q;
  logic [NUM_LINES-1:0] pu_q;
  logic [NUM_LINES-1:0] ldir_we;
  logic [NUM_LINES-1:0] lval_we;
  logic [NUM_LINES-1:0] in_sync;
  logic [REG_W-1:0]     rd_next;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      line_wr_t fld;
      assign fld = unpack_line(wr_data, g * LINE_STRIDE);

      gpio_line_ctl #(.LATCH_MASKS(LATCH_MASKS)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .mask_load (wr_data[MASK_LOAD_BIT]),
        .fields    (fld),
        .dir_o     (dir_q[g]),
        .val_o     (val_q[g]),
        .pu_dis_o  (pu_q[g]),
        .dir_we_o  (ldir_we[g]),
        .val_we_o  (lval_we[g])
      );

      gpio_in_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in[g]),
        .q   (in_sync[g])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      rd_next[i*LINE_STRIDE + FLD_DIR_WE] = ldir_we[i];
      rd_next[i*LINE_STRIDE + FLD_DIR]    = dir_q[i];
      rd_next[i*LINE_STRIDE + FLD_VAL_WE] = lval_we[i];
      rd_next[i*LINE_STRIDE + FLD_VAL]    = val_q[i];
      rd_next[i*LINE_STRIDE + FLD_IN]     = in_sync[i];
      rd_next[i*LINE_STRIDE + FLD_PU_DIS] = pu_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign pad_oe     = dir_q;
  assign pad_out    = val_q;
  assign pad_pu_dis = pu_q;

  initial begin
    if (USED_W > MASK_LOAD_BIT) $error("gpio_pair_regs: too many lines for register");
  end

endmodule

// File: rtl/gpio_pair_chk.sv
module gpio_pair_chk
  import gpio_pair_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter bit LATCH_MASKS = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [REG_W-1:0]     wr_data,
  input logic [REG_W-1:0]     rd_data,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_pu_dis
);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && pad_pu_dis == '0));

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_l
      localparam int B = g * LINE_STRIDE;

      // R5
      dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B+FLD_DIR_WE]) |=> pad_oe[g] == $past(wr_data[B+FLD_DIR]));

      // R5
      val_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B+FLD_VAL_WE]) |=> pad_out[g] == $past(wr_data[B+FLD_VAL]));

      // R4
      pu_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pad_pu_dis[g] == $past(wr_data[B+FLD_PU_DIS]));

      // R4
      pu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pad_pu_dis[g]));

      if (!LATCH_MASKS) begin : g_plain
        // R2
        dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
          !(wr_en && wr_data[B+FLD_DIR_WE]) |=> $stable(pad_oe[g]));

        // R3
        val_hold_chk: assert property (@(posedge clk) disable iff (rst)
          !(wr_en && wr_data[B+FLD_VAL_WE]) |=> $stable(pad_out[g]));

        // R7
        mask_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
          (rd_data[B+FLD_DIR_WE] == 1'b0 && rd_data[B+FLD_VAL_WE] == 1'b0));
      end
    end
  endgenerate

  // R7
  load_bit_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[MASK_LOAD_BIT] == 1'b0);

endmodule

bind gpio_pair_regs gpio_pair_chk #(.NUM_LINES(NUM_LINES), .LATCH_MASKS(LATCH_MASKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pu_dis (pad_pu_dis)
);

// File: tb/tb_gpio_pair_regs.sv
module tb_gpio_pair_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_l;
  logic [1:0]  pad_oe, pad_out, pad_pu_dis;
  logic [1:0]  pad_oe_l, pad_out_l, pad_pu_dis_l;
  logic [1:0]  pad_in, pad_in_l;
  logic [1:0]  ext_low = 2'b00;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // model of the plain build
  logic [1:0] m_dir = '0, m_val = '0, m_pu = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain line: driven level when enabled, otherwise pull-up unless held low externally
  assign pad_in[0]   = pad_oe[0]   ? pad_out[0]   : ~ext_low[0];
  assign pad_in[1]   = pad_oe[1]   ? pad_out[1]   : ~ext_low[1];
  assign pad_in_l[0] = pad_oe_l[0] ? pad_out_l[0] : ~ext_low[0];
  assign pad_in_l[1] = pad_oe_l[1] ? pad_out_l[1] : ~ext_low[1];

  gpio_pair_regs #(.NUM_LINES(2), .LATCH_MASKS(1'b0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in), .pad_pu_dis(pad_pu_dis)
  );

  gpio_pair_regs #(.NUM_LINES(2), .LATCH_MASKS(1'b1)) dut_l (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data_l),
    .pad_oe(pad_oe_l), .pad_out(pad_out_l), .pad_in(pad_in_l), .pad_pu_dis(pad_pu_dis_l)
  );

  function automatic logic [31:0] fld(input int ln, input bit dwe, input bit d,
                                      input bit vwe, input bit v, input bit pu);
    logic [31:0] w = '0;
    w[ln*8+0] = dwe; w[ln*8+1] = d; w[ln*8+2] = vwe; w[ln*8+3] = v; w[ln*8+5] = pu;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // write, then wait until readback has caught up (second edge after the write)
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    for (int ln = 0; ln < 2; ln++) begin
      m_pu[ln] = d[ln*8+5];
      if (d[ln*8+0]) m_dir[ln] = d[ln*8+1];
      if (d[ln*8+2]) m_val[ln] = d[ln*8+3];
    end
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] core_exp();
    logic [31:0] e = '0;
    for (int ln = 0; ln < 2; ln++) begin
      e[ln*8+1] = m_dir[ln]; e[ln*8+3] = m_val[ln]; e[ln*8+5] = m_pu[ln];
    end
    return e;
  endfunction

  localparam logic [31:0] CORE_MASK = 32'h0000_2F2F & ~32'h0000_1010;

  task automatic chk_state(input string req);
    chk(req, {rd_data[25:0] & CORE_MASK[25:0], pad_oe, pad_out, pad_pu_dis},
             {core_exp() & CORE_MASK, m_dir, m_val, m_pu});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", {30'd0, pad_oe}, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: only released inputs (bit 4 and 12) read 1
    chk("R1 readback", rd_data, 32'h0000_1010);
    chk("R1 pads", {26'd0, pad_oe, pad_out, pad_pu_dis}, 32'd0);
    chk("R1 latched readback", rd_data_l, 32'h0000_1010);

    // R2 R3 R5 R9 R10: every start state x every enable/data combination on each line
    for (int ln = 0; ln < 2; ln++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 16; c++) begin
          wr(fld(ln, 1'b1, s[1], 1'b1, s[0], 1'b0));
          wr(fld(ln, c[0], c[1], c[2], c[3], 1'b0));
          chk_state($sformatf("R2 R3 R5 R9 R10 line%0d start%0d combo%0d", ln, s, c));
        end
      end
    end

    // R4: pull-up disable set on both lines, then held through idle, then cleared
    wr(fld(0, 0, 0, 0, 0, 1) | fld(1, 0, 0, 0, 0, 1));
    chk_state("R4 set");
    repeat (5) @(negedge clk);
    chk_state("R4 hold");
    wr(fld(1, 0, 0, 0, 0, 1));
    chk_state("R4 partial clear");
    wr(32'd0);
    chk_state("R4 clear");

    // R5 R6: release both lines, pull data low, then release
    wr(fld(0, 1, 0, 1, 0, 0) | fld(1, 1, 0, 1, 0, 0));
    repeat (3) @(negedge clk);
    chk("R6 released", {30'd0, rd_data[12], rd_data[4]}, 32'd3);
    wr(fld(1, 1, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    chk("R5 drive low", {28'd0, pad_oe[1], pad_out[1], rd_data[12], rd_data[4]}, 32'b1001);
    wr(fld(1, 1, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk("R5 release high", {28'd0, pad_oe[1], pad_out[1], rd_data[12], rd_data[4]}, 32'b0011);

    // R6: external device pulls clock line low; visible on third edge only
    ext_low[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not after second edge", {31'd0, rd_data[4]}, 32'd1);
    @(negedge clk);
    chk("R6 after third edge", {31'd0, rd_data[4]}, 32'd0);
    ext_low[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 back high", {31'd0, rd_data[4]}, 32'd1);

    // R7 R8: store enables on line 0 with dir=1 val=0
    wr(32'h8000_0000 | fld(0, 1, 1, 1, 0, 0));
    chk("R7 plain build enables read 0", rd_data & 32'h8000_0505, 32'd0);
    chk("R8 latched enables read 1", rd_data_l & 32'h8000_0505, 32'h0000_0005);
    // write without enables: plain build holds, latched build updates
    wr(fld(0, 0, 0, 0, 1, 0));
    chk_state("R7 no carry-over of enables");
    chk("R8 update via stored enables", {28'd0, pad_oe_l[0], pad_out_l[0], rd_data_l[1], rd_data_l[3]}, 32'b0101);
    chk("R10 latched other line", {30'd0, pad_oe_l[1], pad_out_l[1]}, {30'd0, m_dir[1], m_val[1]});
    // clear store: old stored enables still apply to this write (dir=1,val=1)
    wr(32'h8000_0000 | fld(0, 0, 1, 0, 1, 0));
    chk("R8 clear write uses old enables", {28'd0, pad_oe_l[0], pad_out_l[0], rd_data_l[0], rd_data_l[2]}, 32'b1100);
    wr(fld(0, 0, 0, 0, 0, 0));
    chk("R8 cleared enables hold fields", {30'd0, pad_oe_l[0], pad_out_l[0]}, 32'b11);

    summary();
  end

endmodule